// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a target device on a two-wire serial bus (one clock line, one data line) that behaves like a small byte-addressed EEPROM. It samples both bus lines with the system clock, finds start and stop conditions, and decodes the device-select byte. It answers only when that byte carries the fixed code and matches the strapped pins that the configuration asks it to compare. After that it either takes a word address and data bytes, or it shifts stored bytes out to the controller.

Written bytes first go into a page-sized staging buffer. The memory array is only updated by a stop that follows at least one complete data byte. An internal busy window then begins. During that window the device stays silent when its own address is sent. The data line is open-drain: the block only ever pulls the line low (`sda_oe` high) or releases it. The surrounding pad and pull-up turn that into the wired-AND bus level.

Top module: `tw_eeprom_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and every memory byte reads as 0xFF.
- R2: The select byte is sent MSB first as code 1010 in bits 7:4, A2 A1 A0 in bits 3:1 and read (1) or write (0) in bit 0. On a match the target pulls SDA low during the ninth clock. A select byte with any other code gets no acknowledge.
- R3: Bit i of `PIN_MASK` decides whether select bit i+1 is compared with `pin_a[i]`. Pins that are not compared are ignored.
- R4: Data bytes move MSB first. A byte that has been written reads back unchanged. `sda_oe` changes only while the synchronised SCL is low.
- R5: A committed write keeps the target from acknowledging its own address for `BUSY_CYCLES` clock cycles. After that window it acknowledges again.
- R6: During a write, the byte address moves up within its `PAGE_BYTES` page and wraps to the start of the same page.
- R7: During a read, the address moves up across page boundaries. The first byte comes from the address set by the last write-address byte, or from the address just after the last byte read or written.
- R8: If the controller does not acknowledge a read byte, the target releases SDA and drives nothing until the next start or stop.
- R9: A stop that follows only a word address changes no memory and starts no busy window.
- R10: A stop in the middle of a data byte discards that byte. A repeated start discards all staged bytes, so no write takes place.
- R11: A random read works: a write select, a word address, a repeated start and a read select return the bytes stored from that address on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND result) |
| pin_a | input | 3 | Strapped address pins, bit 2 = A2 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The embedded assertions check the following on every cycle:
- the drive changes only while SCL is low;
- the drive is released after a stop;
- the address acknowledge never occurs during the busy window;
- the upper address bits stay fixed for the whole of a write burst;
- the busy window starts right after a commit.

The following can only be shown by the bench's bus scenarios, checked against expected bytes and acknowledges:
- pin masking;
- read-back of stored data;
- page wrap;
- sequential reads across a page;
- busy refusal and its later recovery;
- discarding of aborted or restarted writes;
- silence after a controller no-acknowledge.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire EEPROM target.
package tw_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DACK, ST_WADR, ST_AACK,
        ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
    } tw_state_t;
endpackage

// File: rtl/tw_line_watch.sv
// Synchronises SCL/SDA into the clk domain and flags SCL edges plus start
// and stop conditions. Assumes clk is at least 8x faster than SCL.
module tw_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_d, sda_d;

    // two-stage synchroniser plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_d    <= scl_sync[1];
            sda_d    <= sda_sync[1];
        end
    end

    assign scl_s    = scl_sync[1];
    assign sda_s    = sda_sync[1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & ~sda_s & sda_d;
    assign stop_ev  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/tw_busy_timer.sv
// Counts the simulated internal write time. load starts a window of CYCLES
// clocks during which busy is high.
module tw_busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    // down-counter, reloaded on every commit
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= CW'(CYCLES);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    a_r5_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
    a_r5_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == CW'(1)));
endmodule

// File: rtl/tw_store.sv
// Byte memory with a page-sized staging buffer. Staged bytes are copied
// into their page on commit. clear drops staged bytes; it may coincide with
// commit. Memory resets to the erased value 0xFF.
module tw_store #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   stage_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]          stage_idx,
    input  logic [7:0]                             stage_data,
    input  logic                                   clear,
    input  logic                                   commit,
    input  logic [$clog2(MEM_BYTES/PAGE_BYTES)-1:0] page_base,
    input  logic [$clog2(MEM_BYTES)-1:0]           rd_addr,
    output logic [7:0]                             rd_data
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [7:0]            mem [MEM_BYTES];
    logic [7:0]            stage [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;

    // staging buffer: one byte per acknowledged data byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld <= '0;
        end else if (stage_we) begin
            stage[stage_idx] <= stage_data;
            vld[stage_idx]   <= 1'b1;
        end
    end

    // array update: all staged bytes land in the addressed page at once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (vld[i]) mem[{page_base, PW'(i)}] <= stage[i];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tw_eeprom_target.sv
// Two-wire EEPROM target: decodes the select byte, takes a word address and
// data, or streams stored bytes. Assumes MEM_BYTES <= 256 (one address byte),
// PAGE_BYTES < MEM_BYTES, both powers of two, and clk >= 8x SCL rate.
module tw_eeprom_target #(
    parameter int         MEM_BYTES   = 256,
    parameter int         PAGE_BYTES  = 16,
    parameter logic [2:0] PIN_MASK    = 3'b111,
    parameter int         BUSY_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] pin_a,
    output logic       sda_oe
);
    import tw_pkg::*;

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic busy, commit, stage_we, addr_hit;
    logic [2:0] pin_ok;
    logic [7:0] rd_data;

    tw_state_t     state;
    logic [7:0]    sh, tx;
    logic [3:0]    cnt;
    logic          rx_done, rd_mode, have_data, m_ack, oe;
    logic [AW-1:0] ptr;

    tw_line_watch u_watch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    tw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .load(commit), .busy(busy)
    );

    tw_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_idx(ptr[PW-1:0]),
        .stage_data(sh), .clear(start_ev | stop_ev), .commit(commit),
        .page_base(ptr[AW-1:PW]), .rd_addr(ptr), .rd_data(rd_data)
    );

    // per-pin address compare, skipped where the mask bit is clear
    for (genvar g = 0; g < 3; g++) begin : g_pin
        assign pin_ok[g] = !PIN_MASK[g] || (sh[g+1] == pin_a[g]);
    end
    assign addr_hit = (sh[7:4] == DEV_CODE) && (&pin_ok);

    assign commit   = stop_ev && have_data;
    assign stage_we = (state == ST_WDAT) && scl_fall && rx_done;
    assign sda_oe   = oe;

    // bus protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; sh <= '0; tx <= '0; cnt <= '0; rx_done <= 1'b0;
            rd_mode <= 1'b0; have_data <= 1'b0; m_ack <= 1'b0; oe <= 1'b0;
            ptr <= '0;
        end else if (start_ev) begin
            state <= ST_DEV; cnt <= '0; rx_done <= 1'b0; oe <= 1'b0;
            have_data <= 1'b0;
        end else if (stop_ev) begin
            state <= ST_IDLE; oe <= 1'b0; rx_done <= 1'b0; have_data <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == 4'd7) rx_done <= 1'b1;
                    end else if (scl_fall && rx_done) begin
                        rx_done <= 1'b0;
                        cnt     <= '0;
                        if (state == ST_DEV) begin
                            if (addr_hit && !busy) begin
                                oe <= 1'b1; rd_mode <= sh[0]; state <= ST_DACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WADR) begin
                            ptr <= sh[AW-1:0]; oe <= 1'b1; state <= ST_AACK;
                        end else begin
                            ptr <= {ptr[AW-1:PW], PW'(ptr[PW-1:0] + 1'b1)};
                            have_data <= 1'b1; oe <= 1'b1; state <= ST_WACK;
                        end
                    end
                end
                ST_DACK: if (scl_fall) begin
                    if (rd_mode) begin
                        tx <= rd_data; ptr <= ptr + 1'b1; oe <= ~rd_data[7];
                        cnt <= '0; state <= ST_RDAT;
                    end else begin
                        oe <= 1'b0; state <= ST_WADR;
                    end
                end
                ST_AACK, ST_WACK: if (scl_fall) begin
                    oe <= 1'b0; state <= ST_WDAT;
                end
                ST_RDAT: begin
                    if (scl_rise) cnt <= cnt + 1'b1;
                    else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            oe <= 1'b0; cnt <= '0; state <= ST_RACK;
                        end else begin
                            tx <= {tx[6:0], 1'b0}; oe <= ~tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) m_ack <= ~sda_s;
                    else if (scl_fall) begin
                        if (m_ack) begin
                            tx <= rd_data; ptr <= ptr + 1'b1; oe <= ~rd_data[7];
                            state <= ST_RDAT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
    a_r8_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);
    a_r5_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DACK) |-> !busy);
    a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WDAT || state == ST_WACK) &&
         ($past(state) == ST_WDAT || $past(state) == ST_WACK))
        |-> $stable(ptr[AW-1:PW]));
endmodule

// File: tb/test_tw_eeprom_target.sv
// Scoreboard bench: driver tasks push expected read bytes, a monitor pops
// and compares them against bytes clocked off the bus.
module test_tw_eeprom_target;
    localparam int CLK_P = 10;
    localparam int Q     = 8;
    localparam int BUSY  = 1000;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic oe_a, oe_b, sda_bus;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$], act_q[$];
    string      tag_q[$];
    logic       ack, got_ack;
    logic [7:0] rb;

    always #(CLK_P/2) clk = ~clk;
    assign sda_bus = sda_m & ~oe_a & ~oe_b;

    tw_eeprom_target #(.MEM_BYTES(256), .PAGE_BYTES(16), .PIN_MASK(3'b111),
                       .BUSY_CYCLES(BUSY)) i_tw_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .pin_a(3'b011), .sda_oe(oe_a));

    tw_eeprom_target #(.MEM_BYTES(256), .PAGE_BYTES(16), .PIN_MASK(3'b100),
                       .BUSY_CYCLES(BUSY)) i_tw_eeprom_target_m (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .pin_a(3'b100), .sda_oe(oe_b));

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // monitor: compare bytes read off the bus with the expected queue
    always @(negedge clk) begin
        if (act_q.size() > 0) begin
            if (exp_q.size() == 0) chk("scoreboard", 1, 0);
            else chk(tag_q.pop_front(), int'(act_q.pop_front()),
                     int'(exp_q.pop_front()));
        end
    end

    task automatic q_wait(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; q_wait(); scl = 1'b1; q_wait();
        sda_m = 1'b0; q_wait(); scl = 1'b0; q_wait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q_wait(); scl = 1'b1; q_wait(); sda_m = 1'b1; q_wait();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        q_wait(); sda_m = b; q_wait(); scl = 1'b1; q_wait();
        s = sda_bus; q_wait(); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic a);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        a = ~s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
        clk_bit(~m_ack, s);
        sda_m = 1'b1;
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] v, input logic m_ack);
        logic [7:0] g;
        exp_q.push_back(v); tag_q.push_back(tag);
        recv_byte(m_ack, g);
        act_q.push_back(g);
    endtask

    task automatic sel(input logic [7:0] code, output logic a);
        bus_start(); send_byte(code, a);
    endtask

    task automatic set_addr(input logic [7:0] adr);
        sel(8'hA6, got_ack); chk("R11 write select ack", got_ack, 1);
        send_byte(adr, got_ack); chk("R11 word address ack", got_ack, 1);
    endtask

    task automatic wr3(input logic [7:0] adr, input int n,
                       input logic [7:0] d0, d1, d2);
        set_addr(adr);
        send_byte(d0, got_ack); chk("R4 data ack", got_ack, 1);
        if (n > 1) begin send_byte(d1, got_ack); chk("R4 data ack", got_ack, 1); end
        if (n > 2) begin send_byte(d2, got_ack); chk("R4 data ack", got_ack, 1); end
        bus_stop();
    endtask

    task automatic rd_start(input logic [7:0] adr);
        set_addr(adr);
        sel(8'hA7, got_ack); chk("R11 read select ack", got_ack, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 sda_oe after reset", oe_a | oe_b, 0);

        sel(8'hB6, ack); chk("R2 wrong fixed code nack", ack, 0); bus_stop();
        sel(8'hA4, ack); chk("R2 wrong pins nack", ack, 0); bus_stop();
        sel(8'hA6, ack); chk("R2 own address ack", ack, 1); bus_stop();

        sel(8'hAE, ack); chk("R3 masked A1A0=11 ack", ack, 1); bus_stop();
        sel(8'hA8, ack); chk("R3 masked A1A0=00 ack", ack, 1); bus_stop();
        sel(8'hA2, ack); chk("R3 compared A2 mismatch nack", ack, 0); bus_stop();

        // address only, then stop: no busy, memory unchanged
        set_addr(8'h10); bus_stop();
        sel(8'hA6, ack); chk("R9 no busy after address-only", ack, 1); bus_stop();
        sel(8'hA7, ack); chk("R9 current read select ack", ack, 1);
        expect_rd("R1 R9 erased byte", 8'hFF, 1'b0); bus_stop();

        // committed write makes the target busy
        wr3(8'h20, 2, 8'h5A, 8'hC3, 8'h00);
        sel(8'hA6, ack); chk("R5 nack while busy", ack, 0); bus_stop();
        repeat (BUSY + 20) @(negedge clk);
        sel(8'hA6, ack); chk("R5 ack after busy", ack, 1); bus_stop();

        rd_start(8'h20);
        expect_rd("R4 R11 readback 0", 8'h5A, 1'b1);
        expect_rd("R4 R7 readback 1", 8'hC3, 1'b0);
        bus_stop();

        // page wrap on write, sequential read across a page
        wr3(8'h3E, 3, 8'h11, 8'h22, 8'h33);
        repeat (BUSY + 20) @(negedge clk);
        rd_start(8'h3E);
        expect_rd("R6 byte at 3E", 8'h11, 1'b1);
        expect_rd("R6 byte at 3F", 8'h22, 1'b1);
        expect_rd("R7 read crosses to 40", 8'hFF, 1'b0);
        bus_stop();
        rd_start(8'h30);
        expect_rd("R6 wrapped byte at 30", 8'h33, 1'b0);
        bus_stop();

        // stop in the middle of a data byte
        set_addr(8'h50);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, ack);
        bus_stop();
        sel(8'hA6, ack); chk("R10 no busy after aborted byte", ack, 1); bus_stop();
        rd_start(8'h50);
        expect_rd("R10 aborted byte not stored", 8'hFF, 1'b0); bus_stop();

        // repeated start discards staged data
        set_addr(8'h60);
        send_byte(8'h99, ack); chk("R10 staged data ack", ack, 1);
        sel(8'hA7, ack); chk("R10 read after restart ack", ack, 1);
        expect_rd("R10 pointer past staged byte", 8'hFF, 1'b0); bus_stop();
        sel(8'hA6, ack); chk("R10 no busy after restart", ack, 1); bus_stop();
        rd_start(8'h60);
        expect_rd("R10 restarted write discarded", 8'hFF, 1'b0); bus_stop();

        // controller no-acknowledge silences the target
        rd_start(8'h20);
        expect_rd("R8 first byte", 8'h5A, 1'b0);
        recv_byte(1'b0, rb);
        chk("R8 bus released after nack", rb, 8'hFF);
        chk("R8 sda_oe low after nack", oe_a, 0);
        bus_stop();

        repeat (10) @(negedge clk);
        summary();
    end
endmodule